// File: doc/BRIEF.md
# Paging-Structure Entry Cache

This block keeps recently used upper-level page-table entries for a four-level, 48-bit virtual address translation scheme. The page walker uses it to skip levels of a walk after a TLB miss. The three upper directory levels each have their own small array. Each array is tagged by the part of the virtual address that one entry of that level covers:

| Level code | Directory level | Coverage | Tag bits |
|---|---|---|---|
| 1 | top | 512 GB | VA[47:39] |
| 2 | second | 1 GB | VA[47:30] |
| 3 | third | 2 MB | VA[47:21] |

Leaf entries are never stored here.

A lookup presents the upper address bits. One cycle later the block returns a level code and a 40-bit physical frame pointer to the next-level table. The level code gives the deepest level that hit, or zero for a miss. The walker writes entries back after a walk through the fill port. A single-address invalidate removes every cached directory entry that covers the address. A flush empties all three arrays, for example on an address-space switch.

Top module: `pscache`

## Requirements
- R1: While reset is active and after it is released, every entry of all three levels is invalid. A lookup issued after reset returns level code 0 and pointer 0.
- R2: Level 1 tags use VA[47:39], level 2 tags use VA[47:30] and level 3 tags use VA[47:21]. A level hits when it holds a valid entry whose tag equals the matching prefix of the lookup address.
- R3: When several levels hit, the response carries the highest-numbered (deepest) hitting level and that level's pointer. Priority runs 3 over 2 over 1.
- R4: The response appears on the clock edge that follows the lookup. The response is code 0 with pointer 0 on a miss and in any cycle with no lookup. A lookup sees the contents as they were before any write in the same cycle.
- R5: A fill with level code 1, 2 or 3 stores the tag of the fill address and the pointer into that level. A fill with level code 0 changes nothing.
- R6: A fill whose tag already hits in its level overwrites that entry's pointer in place. It does not create a second copy and does not consume a replacement slot.
- R7: Each level holds 32 entries. New tags take slots in round-robin order, starting at slot 0 after reset. The 33rd distinct fill into a full level evicts the oldest allocation.
- R8: An invalidate removes, at all three levels, every entry whose tag equals the matching prefix of the invalidate address. Entries with other tags are untouched.
- R9: A flush invalidates all entries of all three levels at once. Round-robin allocation then restarts at slot 0.
- R10: A fill in the same cycle as an invalidate or a flush is discarded. An invalidate in the same cycle as a flush has no effect beyond the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va_hi | input | 27 | Lookup address bits VA[47:21] |
| rsp_level | output | 2 | Deepest hit level code, 0 for a miss |
| rsp_ptr | output | 40 | Next-level table frame pointer of the hit, 0 for a miss |
| fill_valid | input | 1 | Fill request |
| fill_level | input | 2 | Target level code 1..3 (0 is ignored) |
| fill_va_hi | input | 27 | Fill address bits VA[47:21] |
| fill_ptr | input | 40 | Pointer to store |
| inv_valid | input | 1 | Single-address invalidate |
| inv_va_hi | input | 27 | Invalidate address bits VA[47:21] |
| flush | input | 1 | Clear all levels |

## Verification
The bench targets addresses that hit at two or three levels at once. A design that resolves priority the wrong way returns a shallow level code and the wrong pointer. Repeated fills of one tag are checked against a full level. A design that duplicates entries loses an unrelated tag earlier than round-robin order allows. The 33rd distinct fill and fills colliding with an invalidate or flush in the same cycle are also exercised. Those cases expose an off-by-one victim pointer or a write that slips past the higher-priority clear. Random traffic over a small pool of addresses keeps all three levels busy with hits, evictions and invalidates. Every response is compared with a reference model.

// File: rtl/psc_pkg.sv
// Shared constants for the paging-structure entry cache.
// Assumes a four-level table walk with 4 KB pages and 9 index bits per level.
package psc_pkg;
    localparam int VA_W        = 48;
    localparam int PAGE_SHIFT  = 12;
    localparam int IDX_BITS    = 9;
    localparam int TABLE_LVLS  = 4;
    localparam int CACHED_LVLS = TABLE_LVLS - 1;
    localparam int PTR_W       = 40;
    localparam int ENTRIES     = 32;
    localparam int CODE_W      = 2;

    // Lowest address bit used by any tag level (level CACHED_LVLS).
    localparam int MIN_SHIFT   = PAGE_SHIFT + IDX_BITS;
    localparam int HI_W        = VA_W - MIN_SHIFT;

    // Address bit where the tag of level code l (1 = top) starts.
    function automatic int lvl_shift(input int l);
        return PAGE_SHIFT + IDX_BITS * (TABLE_LVLS - l);
    endfunction
endpackage

// File: rtl/psc_level.sv
// One level array of the paging-structure cache.
// Holds ENTRIES tagged pointers with round-robin allocation and in-place
// update of an already-present tag. clr has priority over inv_en, which
// has priority over wr_en. Assumes no duplicate tags (kept by design).
module psc_level #(
    parameter int TAG_W   = 9,
    parameter int PTR_W   = 40,
    parameter int ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PTR_W-1:0] lk_ptr,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             inv_en,
    input  logic [TAG_W-1:0] inv_tag,
    input  logic             clr
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]     valid;
    logic [TAG_W-1:0]       tags [ENTRIES];
    logic [PTR_W-1:0]       ptrs [ENTRIES];
    logic [IDX_W-1:0]       rr;

    logic [ENTRIES-1:0]     lk_match;
    logic [ENTRIES-1:0]     wr_match;
    logic [ENTRIES-1:0]     inv_match;

    // Per-entry comparators for the three request sources.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign lk_match[i]  = valid[i] && (tags[i] == lk_tag);
        assign wr_match[i]  = valid[i] && (tags[i] == wr_tag);
        assign inv_match[i] = valid[i] && (tags[i] == inv_tag);
    end

    // Lookup read: OR-mux of the (at most one) matching entry.
    always_comb begin
        lk_ptr = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (lk_match[i]) lk_ptr = lk_ptr | ptrs[i];
    end
    assign lk_hit = |lk_match;

    // Index of the entry already holding the fill tag.
    logic [IDX_W-1:0] wr_idx;
    always_comb begin
        wr_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (wr_match[i]) wr_idx = IDX_W'(i);
    end

    // Valid bits and round-robin victim pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            valid <= '0;
            rr    <= '0;
        end else if (inv_en) begin
            valid <= valid & ~inv_match;
        end else if (wr_en) begin
            if (|wr_match) begin
                valid[wr_idx] <= 1'b1;
            end else begin
                valid[rr] <= 1'b1;
                rr        <= (rr == LAST) ? '0 : rr + 1'b1;
            end
        end
    end

    // Tag and pointer storage; contents only matter where valid is set.
    always_ff @(posedge clk) begin
        if (rst_n && !clr && !inv_en && wr_en) begin
            if (|wr_match) begin
                ptrs[wr_idx] <= wr_ptr;
            end else begin
                tags[rr] <= wr_tag;
                ptrs[rr] <= wr_ptr;
            end
        end
    end
endmodule

// File: rtl/psc_pick.sv
// Deepest-hit selector: picks the highest-numbered level that hit and
// its pointer. Bit g of hit belongs to level code g+1.
module psc_pick #(
    parameter int LVLS   = 3,
    parameter int PTR_W  = 40,
    parameter int CODE_W = 2
) (
    input  logic [LVLS-1:0]             hit,
    input  logic [LVLS-1:0][PTR_W-1:0]  ptr,
    output logic [CODE_W-1:0]           code,
    output logic [PTR_W-1:0]            sel_ptr
);
    // Scan shallow to deep so the deepest hit wins.
    always_comb begin
        code    = '0;
        sel_ptr = '0;
        for (int g = 0; g < LVLS; g++) begin
            if (hit[g]) begin
                code    = CODE_W'(g + 1);
                sel_ptr = ptr[g];
            end
        end
    end
endmodule

// File: rtl/pscache.sv
// Paging-structure entry cache top. Instantiates one array per cached
// directory level with a tag width fitting that level's coverage, selects
// the deepest hit and registers the response. Flush beats invalidate,
// and both beat a fill in the same cycle.
module pscache
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [HI_W-1:0]   lk_va_hi,
    output logic [CODE_W-1:0] rsp_level,
    output logic [PTR_W-1:0]  rsp_ptr,
    input  logic              fill_valid,
    input  logic [CODE_W-1:0] fill_level,
    input  logic [HI_W-1:0]   fill_va_hi,
    input  logic [PTR_W-1:0]  fill_ptr,
    input  logic              inv_valid,
    input  logic [HI_W-1:0]   inv_va_hi,
    input  logic              flush
);
    logic [CACHED_LVLS-1:0]             hit;
    logic [CACHED_LVLS-1:0][PTR_W-1:0]  hit_ptr;
    logic [CODE_W-1:0]                  pick_code;
    logic [PTR_W-1:0]                   pick_ptr;

    // Priority gating of the maintenance requests.
    logic inv_go, fill_go;
    assign inv_go  = inv_valid && !flush;
    assign fill_go = fill_valid && !inv_valid && !flush;

    for (genvar g = 0; g < CACHED_LVLS; g++) begin : g_lvl
        localparam int SH    = lvl_shift(g + 1) - MIN_SHIFT;
        localparam int TAG_W = HI_W - SH;

        psc_level #(.TAG_W(TAG_W), .PTR_W(PTR_W), .ENTRIES(ENTRIES)) u_level (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_tag  (lk_va_hi[HI_W-1:SH]),
            .lk_hit  (hit[g]),
            .lk_ptr  (hit_ptr[g]),
            .wr_en   (fill_go && (fill_level == CODE_W'(g + 1))),
            .wr_tag  (fill_va_hi[HI_W-1:SH]),
            .wr_ptr  (fill_ptr),
            .inv_en  (inv_go),
            .inv_tag (inv_va_hi[HI_W-1:SH]),
            .clr     (flush)
        );
    end

    psc_pick #(.LVLS(CACHED_LVLS), .PTR_W(PTR_W), .CODE_W(CODE_W)) u_pick (
        .hit     (hit),
        .ptr     (hit_ptr),
        .code    (pick_code),
        .sel_ptr (pick_ptr)
    );

    // Response register: one cycle lookup latency, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !lk_valid) begin
            rsp_level <= '0;
            rsp_ptr   <= '0;
        end else begin
            rsp_level <= pick_code;
            rsp_ptr   <= pick_ptr;
        end
    end
endmodule

// File: rtl/pscache_chk.sv
// Port-level temporal checks for pscache, bound onto every instance.
module pscache_chk
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [HI_W-1:0]   lk_va_hi,
    input  logic [CODE_W-1:0] rsp_level,
    input  logic [PTR_W-1:0]  rsp_ptr,
    input  logic              inv_valid,
    input  logic [HI_W-1:0]   inv_va_hi,
    input  logic              flush
);
    logic            flush_q;
    logic            inv_q;
    logic [HI_W-1:0] inv_va_q;

    // Remember last cycle's maintenance requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q  <= 1'b0;
            inv_q    <= 1'b0;
            inv_va_q <= '0;
        end else begin
            flush_q  <= flush;
            inv_q    <= inv_valid && !flush;
            inv_va_q <= inv_va_hi;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (rsp_level == '0 && rsp_ptr == '0));

    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (rsp_level == '0 && rsp_ptr == '0));

    a_r4_miss_no_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_level == '0) |-> (rsp_ptr == '0));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && lk_valid) |=> (rsp_level == '0));

    a_r8_inv_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_q && lk_valid && lk_va_hi == inv_va_q) |=> (rsp_level == '0));
endmodule

bind pscache pscache_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_va_hi  (lk_va_hi),
    .rsp_level (rsp_level),
    .rsp_ptr   (rsp_ptr),
    .inv_valid (inv_valid),
    .inv_va_hi (inv_va_hi),
    .flush     (flush)
);

// File: tb/pscache_bench.sv
// Self-checking bench for pscache: directed corner cases plus seeded
// random traffic, compared against a behavioural model of the requirements.
module pscache_bench;
    import psc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lk_valid;
    logic [HI_W-1:0]   lk_va_hi;
    logic [CODE_W-1:0] rsp_level;
    logic [PTR_W-1:0]  rsp_ptr;
    logic              fill_valid;
    logic [CODE_W-1:0] fill_level;
    logic [HI_W-1:0]   fill_va_hi;
    logic [PTR_W-1:0]  fill_ptr;
    logic              inv_valid;
    logic [HI_W-1:0]   inv_va_hi;
    logic              flush;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pscache u_pscache (.*);

    // Reference model: tags kept as full upper-address prefixes.
    logic [HI_W-1:0]  m_tag [1:3][ENTRIES];
    logic [PTR_W-1:0] m_ptr [1:3][ENTRIES];
    bit               m_val [1:3][ENTRIES];
    int               m_rr  [1:3];

    function automatic logic [HI_W-1:0] pfx(input int l, input logic [HI_W-1:0] va);
        return va >> (lvl_shift(l) - MIN_SHIFT);
    endfunction

    function automatic void m_flush();
        for (int l = 1; l <= 3; l++) begin
            m_rr[l] = 0;
            for (int i = 0; i < ENTRIES; i++) m_val[l][i] = 0;
        end
    endfunction

    function automatic void m_inv(input logic [HI_W-1:0] va);
        for (int l = 1; l <= 3; l++)
            for (int i = 0; i < ENTRIES; i++)
                if (m_val[l][i] && m_tag[l][i] == pfx(l, va)) m_val[l][i] = 0;
    endfunction

    function automatic void m_fill(input int l, input logic [HI_W-1:0] va,
                                   input logic [PTR_W-1:0] p);
        for (int i = 0; i < ENTRIES; i++)
            if (m_val[l][i] && m_tag[l][i] == pfx(l, va)) begin
                m_ptr[l][i] = p;
                return;
            end
        m_val[l][m_rr[l]] = 1;
        m_tag[l][m_rr[l]] = pfx(l, va);
        m_ptr[l][m_rr[l]] = p;
        m_rr[l] = (m_rr[l] + 1) % ENTRIES;
    endfunction

    function automatic void m_look(input logic [HI_W-1:0] va,
                                   output logic [CODE_W-1:0] c,
                                   output logic [PTR_W-1:0] p);
        c = '0;
        p = '0;
        for (int l = 3; l >= 1; l--)
            for (int i = 0; i < ENTRIES; i++)
                if (c == 0 && m_val[l][i] && m_tag[l][i] == pfx(l, va)) begin
                    c = CODE_W'(l);
                    p = m_ptr[l][i];
                end
    endfunction

    // Build an upper address from per-level index fields.
    function automatic logic [HI_W-1:0] mk(input int a, input int b, input int c);
        return {9'(a), 9'(b), 9'(c)};
    endfunction

    function automatic logic [HI_W-1:0] rva();
        return mk($urandom % 2, $urandom % 4, $urandom % 48);
    endfunction

    // One clock: drive at negedge, update model, compare after the edge.
    task automatic cyc(input bit lk, input logic [HI_W-1:0] lva,
                       input bit fv, input int fl, input logic [HI_W-1:0] fva,
                       input logic [PTR_W-1:0] fp,
                       input bit iv, input logic [HI_W-1:0] iva,
                       input bit fls, input string req);
        logic [CODE_W-1:0] ec;
        logic [PTR_W-1:0]  ep;
        lk_valid = lk; lk_va_hi = lva;
        fill_valid = fv; fill_level = CODE_W'(fl); fill_va_hi = fva; fill_ptr = fp;
        inv_valid = iv; inv_va_hi = iva; flush = fls;
        if (lk) m_look(lva, ec, ep);
        else begin ec = '0; ep = '0; end
        if (fls) m_flush();
        else if (iv) m_inv(iva);
        else if (fv && fl != 0) m_fill(fl, fva, fp);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_level !== ec || rsp_ptr !== ep) begin
            errors++;
            $display("FAIL %s: va=%h got level %0d ptr %h, expected level %0d ptr %h",
                     req, lva, rsp_level, rsp_ptr, ec, ep);
        end
    endtask

    task automatic look(input logic [HI_W-1:0] va, input string req);
        cyc(1, va, 0, 0, '0, '0, 0, '0, 0, req);
    endtask

    task automatic fill(input int l, input logic [HI_W-1:0] va,
                        input logic [PTR_W-1:0] p, input string req);
        cyc(0, '0, 1, l, va, p, 0, '0, 0, req);
    endtask

    // Directly check an expected code, independent of the model.
    task automatic expect_code(input int c, input string req);
        checks++;
        if (rsp_level !== CODE_W'(c)) begin
            errors++;
            $display("FAIL %s: got level %0d, expected %0d", req, rsp_level, c);
        end
    endtask

    initial begin
        logic [HI_W-1:0] a;
        void'($urandom(32'd20240611));
        m_flush();
        rst_n = 0; lk_valid = 0; lk_va_hi = '0; fill_valid = 0; fill_level = '0;
        fill_va_hi = '0; fill_ptr = '0; inv_valid = 0; inv_va_hi = '0; flush = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: empty after reset.
        look(mk(0, 0, 0), "R1");
        expect_code(0, "R1");

        // R2/R3: build up levels for one address, deepest wins.
        a = mk(1, 2, 3);
        fill(1, a, 40'h11, "R5");
        look(a, "R2");
        expect_code(1, "R2");
        fill(2, a, 40'h22, "R5");
        look(a, "R3");
        expect_code(2, "R3");
        fill(3, a, 40'h33, "R5");
        look(a, "R3");
        expect_code(3, "R3");
        look(mk(1, 2, 4), "R2");
        expect_code(2, "R2");
        look(mk(1, 3, 3), "R2");
        expect_code(1, "R2");

        // R4: lookup in same cycle as invalidate sees old contents.
        cyc(1, a, 0, 0, '0, '0, 1, a, 0, "R4");
        expect_code(3, "R4");
        // R8: all levels covering the address are gone.
        look(a, "R8");
        expect_code(0, "R8");

        // R5: fill level code 0 has no effect.
        cyc(0, '0, 1, 0, a, 40'h99, 0, '0, 0, "R5");
        look(a, "R5");
        expect_code(0, "R5");

        // R10: fill colliding with invalidate or flush is discarded.
        cyc(0, '0, 1, 3, a, 40'h44, 1, mk(0, 0, 0), 0, "R10");
        look(a, "R10");
        expect_code(0, "R10");
        cyc(0, '0, 1, 2, a, 40'h45, 0, '0, 1, "R10");
        look(a, "R10");
        expect_code(0, "R10");

        // R6: repeated tag updates in place, consumes one slot.
        fill(3, a, 40'h55, "R6");
        fill(3, a, 40'h66, "R6");
        for (int i = 0; i < ENTRIES - 1; i++) fill(3, mk(0, 1, i), 40'(i + 100), "R6");
        look(a, "R6");
        expect_code(3, "R6");

        // R9/R7: flush, then 33 distinct top-level fills evict the first.
        cyc(0, '0, 0, 0, '0, '0, 0, '0, 1, "R9");
        look(a, "R9");
        expect_code(0, "R9");
        for (int i = 0; i <= ENTRIES; i++) fill(1, mk(i, 0, 0), 40'(i + 7), "R7");
        look(mk(0, 0, 0), "R7");
        expect_code(0, "R7");
        look(mk(1, 0, 0), "R7");
        expect_code(1, "R7");
        look(mk(ENTRIES, 5, 5), "R7");
        expect_code(1, "R7");

        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit lk, fv, iv, fl_s;
            r    = $urandom % 100;
            lk   = ($urandom % 10) < 7;
            fv   = r < 55;
            iv   = (r >= 55 && r < 65) || (r < 5);
            fl_s = (r >= 98);
            cyc(lk, rva(), fv, $urandom % 4, rva(), 40'($urandom), iv, rva(), fl_s, "R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule